// File: doc/BRIEF.md
# Equivalent-Time Threshold-Search Sampling Sequencer

This block rebuilds a repetitive analog waveform one point at a time. It has no converter of its own. Instead it drives three things: a threshold DAC, a latching comparator and a programmable trigger delay. For each delay setting, the threshold code starts at full scale and steps down by one on every repetition of the input. It stops when the comparator reports that the signal rose above the threshold. The code held at that moment is the sample for that delay point.

The sample is written to an external memory at the next sequential address. The sequencer then pulses the comparator-clear output, moves the delay forward by a fixed step and searches again from full scale. The first sample becomes a reference peak. Once enough points have been taken, a later sample that lies within a user tolerance of that reference ends the capture as one full period. The capture also ends after the last point of the delay range. A start pulse clears everything and begins a new capture.

Top module: `ets_sequencer`

## Requirements
- R1: After reset, and in the cycle after a start pulse, the outputs are as follows: `dac_code` is 255, `dly_code` equals DLY_MIN, `count` is 0 and `done` is 0. In the cycle after a start pulse, `latch_clr` is also high. A start pulse restarts the capture from any state.
- R2: While searching, each trigger pulse without a detection lowers `dac_code` by exactly one. `cmp_latch` is examined only in the cycle that follows a trigger.
- R3: A detection causes a one-cycle `wr_en`. During that cycle `wr_data` equals the threshold code held when the detection was seen, and `wr_addr` equals the number of samples written before it (0, 1, 2, ...).
- R4: If the code is 0 and the comparator has still not latched, the value 0 is written for that delay point and the capture continues.
- R5: After every write that does not end the capture, `latch_clr` is high for exactly one cycle with `dac_code` back at 255. The next point's delay is the previous delay plus DLY_STEP.
- R6: `dly_code` never exceeds DLY_MAX; a step past it lands on DLY_MAX. A sample taken at DLY_MAX ends the capture.
- R7: Sample 0 is the reference. The capture ends on the first sample k with k >= MIN_PTS and |sample − reference| <= `tol`. At that point `done` rises and `count` is k+1.
- R8: Samples with index below MIN_PTS never end the capture, even when they equal the reference.
- R9: `cmp_latch` has no effect in the `latch_clr` cycle. A stale latch level there produces no write.
- R10: Once `done` is high, it stays high and `count` holds until the next start pulse. No further writes happen in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: clear state and begin a capture |
| trig | input | 1 | One-cycle pulse per input repetition |
| cmp_latch | input | 1 | Latched comparator result, high once the signal exceeded the threshold |
| tol | input | CODE_W (8) | End-of-period match tolerance in threshold codes |
| dac_code | output | CODE_W (8) | Threshold DAC code |
| dly_code | output | DLY_W (11) | Trigger delay code, one unit per 5 ps |
| latch_clr | output | 1 | One-cycle comparator latch clear |
| wr_en | output | 1 | Sample write strobe |
| wr_addr | output | ADDR_W (10) | Sample write address |
| wr_data | output | CODE_W (8) | Sample value |
| done | output | 1 | Capture complete |
| count | output | ADDR_W+1 (11) | Number of samples written |

## Verification
A wrong threshold count shows up as a written sample that is off by the error, at the very next write. A wrong delay register shows up as a delay that does not match the write index, in that same write cycle. A reference captured at the wrong time, or a wrong minimum-gap count, shows up only when the capture ends. The capture then stops early or late, so `count` and the number of writes differ from the bench's prediction. A latch that is not ignored during the clear cycle writes a duplicate value at a wrong address within two cycles.

// File: rtl/ets_pkg.sv
package ets_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_SEARCH,
      ST_CHECK,
      ST_RECORD,
      ST_DONE
   } seq_state_t;

   function automatic int unsigned ets_points(input int unsigned lo, input int unsigned hi,
                                              input int unsigned step);
      return (hi - lo + step - 1) / step + 1;
   endfunction

endpackage

// File: rtl/ets_thresh_search.sv
module ets_thresh_search #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_max,
   input  logic              step_down,
   output logic [CODE_W-1:0] code,
   output logic              at_zero
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;
   localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= CODE_MAX;
      end else if (load_max) begin
         code <= CODE_MAX;
      end else if (step_down && !at_zero) begin
         code <= code - CODE_ONE;
      end
   end

   assign at_zero = (code == '0);
endmodule

// File: rtl/ets_delay_step.sv
module ets_delay_step #(
   parameter int DLY_W    = 11,
   parameter int DLY_MIN  = 400,
   parameter int DLY_MAX  = 1400,
   parameter int DLY_STEP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             adv,
   output logic [DLY_W-1:0] dly,
   output logic             at_max
);
   localparam logic [DLY_W-1:0] MIN_C  = DLY_W'(DLY_MIN);
   localparam logic [DLY_W-1:0] MAX_C  = DLY_W'(DLY_MAX);
   localparam logic [DLY_W-1:0] STEP_C = DLY_W'(DLY_STEP);

   logic [DLY_W-1:0] nxt;

   generate
      if (DLY_STEP == 1) begin : g_unit
         assign nxt = at_max ? MAX_C : dly + STEP_C;
      end else begin : g_multi
         logic [DLY_W:0] sum;
         assign sum = {1'b0, dly} + {1'b0, STEP_C};
         assign nxt = (sum > {1'b0, MAX_C}) ? MAX_C : sum[DLY_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly <= MIN_C;
      end else if (init) begin
         dly <= MIN_C;
      end else if (adv) begin
         dly <= nxt;
      end
   end

   assign at_max = (dly >= MAX_C);
endmodule

// File: rtl/ets_period_detect.sv
module ets_period_detect #(
   parameter int CODE_W  = 8,
   parameter int IDX_W   = 11,
   parameter int MIN_PTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [IDX_W-1:0]  idx,
   input  logic [CODE_W-1:0] sample,
   input  logic [CODE_W-1:0] tol,
   output logic              hit
);
   localparam logic [IDX_W-1:0] GAP_C = IDX_W'(MIN_PTS);

   logic [CODE_W-1:0] ref_q;
   logic [CODE_W-1:0] diff;
   logic              gap_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= '0;
      end else if (clear) begin
         ref_q <= '0;
      end else if (take && idx == '0) begin
         ref_q <= sample;
      end
   end

   assign diff   = (sample >= ref_q) ? (sample - ref_q) : (ref_q - sample);
   assign gap_ok = (idx >= GAP_C);
   assign hit    = gap_ok && (diff <= tol);
endmodule

// File: rtl/ets_sequencer.sv
module ets_sequencer
   import ets_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int DLY_W    = 11,
   parameter int DLY_MIN  = 400,
   parameter int DLY_MAX  = 1400,
   parameter int DLY_STEP = 1,
   parameter int ADDR_W   = 10,
   parameter int MIN_PTS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              trig,
   input  logic              cmp_latch,
   input  logic [CODE_W-1:0] tol,
   output logic [CODE_W-1:0] dac_code,
   output logic [DLY_W-1:0]  dly_code,
   output logic              latch_clr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [CODE_W-1:0] wr_data,
   output logic              done,
   output logic [ADDR_W:0]   count
);
   localparam int CNT_W = ADDR_W + 1;
   localparam int NPTS  = ets_points(DLY_MIN, DLY_MAX, DLY_STEP);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   initial begin
      assert (CODE_W >= 2 && CODE_W <= 16) else $error("CODE_W out of range");
      assert (DLY_STEP >= 1) else $error("DLY_STEP must be positive");
      assert (DLY_MAX > DLY_MIN) else $error("delay range empty");
      assert (DLY_MAX < (1 << DLY_W)) else $error("DLY_W too narrow");
      assert (MIN_PTS >= 1) else $error("MIN_PTS must be at least 1");
      assert (NPTS <= (1 << ADDR_W)) else $error("ADDR_W too narrow for range");
   end

   seq_state_t state;
   logic       at_zero;
   logic       at_max;
   logic       hit;
   logic       rec;
   logic       finish;

   assign rec    = (state == ST_RECORD);
   assign finish = hit || at_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else if (start) begin
         state <= ST_CLEAR;
      end else begin
         case (state)
            ST_CLEAR:  state <= ST_SEARCH;
            ST_SEARCH: if (trig) state <= ST_CHECK;
            ST_CHECK:  state <= (cmp_latch || at_zero) ? ST_RECORD : ST_SEARCH;
            ST_RECORD: state <= finish ? ST_DONE : ST_CLEAR;
            default:   state <= state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (start) begin
         count <= '0;
      end else if (rec) begin
         count <= count + CNT_ONE;
      end
   end

   ets_thresh_search #(.CODE_W(CODE_W)) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_max  (start || rec),
      .step_down (state == ST_CHECK && !cmp_latch),
      .code      (dac_code),
      .at_zero   (at_zero)
   );

   ets_delay_step #(
      .DLY_W   (DLY_W),
      .DLY_MIN (DLY_MIN),
      .DLY_MAX (DLY_MAX),
      .DLY_STEP(DLY_STEP)
   ) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (start),
      .adv    (rec && !finish),
      .dly    (dly_code),
      .at_max (at_max)
   );

   ets_period_detect #(
      .CODE_W (CODE_W),
      .IDX_W  (CNT_W),
      .MIN_PTS(MIN_PTS)
   ) u_per (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .take   (rec),
      .idx    (count),
      .sample (dac_code),
      .tol    (tol),
      .hit    (hit)
   );

   assign latch_clr = (state == ST_CLEAR);
   assign wr_en     = rec;
   assign wr_addr   = count[ADDR_W-1:0];
   assign wr_data   = dac_code;
   assign done      = (state == ST_DONE);
endmodule

// File: rtl/ets_sequencer_chk.sv
module ets_sequencer_chk #(
   parameter int CODE_W  = 8,
   parameter int DLY_W   = 11,
   parameter int DLY_MIN = 400,
   parameter int DLY_MAX = 1400,
   parameter int ADDR_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CODE_W-1:0] dac_code,
   input logic [DLY_W-1:0]  dly_code,
   input logic              latch_clr,
   input logic              wr_en,
   input logic              done,
   input logic [ADDR_W:0]   count
);
   localparam logic [CODE_W-1:0] ONE_C = {{(CODE_W-1){1'b0}}, 1'b1};

   // R5
   clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_clr |=> !latch_clr);

   // R2
   dac_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && !$past(wr_en) && dac_code != $past(dac_code))
         |-> (dac_code + ONE_C) == $past(dac_code));

   // R6
   dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_code <= DLY_W'(DLY_MAX)) && (dly_code >= DLY_W'(DLY_MIN)));

   // R6
   dly_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> dly_code >= $past(dly_code));

   // R3
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(count)));

   // R9
   clr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_clr |-> (!wr_en && dac_code == '1));

   // R7
   wr_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !done);
endmodule

bind ets_sequencer ets_sequencer_chk #(
   .CODE_W (CODE_W),
   .DLY_W  (DLY_W),
   .DLY_MIN(DLY_MIN),
   .DLY_MAX(DLY_MAX),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .dac_code (dac_code),
   .dly_code (dly_code),
   .latch_clr(latch_clr),
   .wr_en    (wr_en),
   .done     (done),
   .count    (count)
);

// File: tb/sim_ets_sequencer.sv
module sim_ets_sequencer;
   localparam int DMIN = 400;
   localparam int DMAX = 1400;
   localparam int DSTEP = 50;
   localparam int GAP = 3;
   localparam int NPTS = (DMAX - DMIN + DSTEP - 1) / DSTEP + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        trig = 1'b0;
   logic        lat = 1'b0;
   logic        glitch_en = 1'b1;
   logic [7:0]  tol = 8'd0;
   logic        cmp;
   logic [7:0]  dac_code;
   logic [10:0] dly_code;
   logic        latch_clr;
   logic        wr_en;
   logic [9:0]  wr_addr;
   logic [7:0]  wr_data;
   logic        done;
   logic [10:0] count;

   int wv [0:31];
   int expd [0:31];
   int exp_n;
   int wcount;
   int nchecks = 0;
   int nerr = 0;
   int cycles = 0;
   bit prev_clr = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign cmp = lat | (glitch_en & latch_clr);

   ets_sequencer #(
      .DLY_MIN(DMIN), .DLY_MAX(DMAX), .DLY_STEP(DSTEP), .MIN_PTS(GAP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .trig(trig), .cmp_latch(cmp),
      .tol(tol), .dac_code(dac_code), .dly_code(dly_code), .latch_clr(latch_clr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .count(count)
   );

   function automatic int rec_of(input int v);
      return (v == 0) ? 0 : v - 1;
   endfunction

   function automatic int dly_of(input int k);
      int d;
      d = DMIN + k * DSTEP;
      return (d > DMAX) ? DMAX : d;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   endtask

   // comparator model: latches when the waveform at the current delay exceeds the threshold
   always @(posedge clk) begin
      if (!rst_n || latch_clr) begin
         lat <= 1'b0;
      end else if (trig) begin
         int idx;
         idx = (int'(dly_code) - DMIN) / DSTEP;
         if (idx >= 0 && idx < 32 && wv[idx] > int'(dac_code)) lat <= 1'b1;
      end
   end

   // write monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (latch_clr) begin
            chk(!prev_clr, "R5 clear pulse width", 2, 1);
            chk(dac_code == 8'd255, "R5 threshold reload", int'(dac_code), 255);
            chk(!wr_en, "R9 no write in clear cycle", int'(wr_en), 0);
         end
         prev_clr = latch_clr;
         if (wr_en) begin
            if (wcount >= exp_n) begin
               chk(1'b0, "R10 write after end", wcount, exp_n - 1);
            end else begin
               chk(int'(wr_addr) == wcount, "R3 address", int'(wr_addr), wcount);
               chk(int'(wr_data) == expd[wcount],
                   (expd[wcount] == 0) ? "R4 zero sample" : "R3 sample value",
                   int'(wr_data), expd[wcount]);
               chk(int'(dly_code) == dly_of(wcount), "R6 delay code",
                   int'(dly_code), dly_of(wcount));
            end
            wcount++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         nerr++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
         report();
      end
   end

   task automatic plan();
      int r;
      r = rec_of(wv[0]);
      exp_n = NPTS;
      for (int k = 0; k < NPTS; k++) begin
         int s;
         int d;
         s = rec_of(wv[k]);
         expd[k] = s;
         d = (s > r) ? s - r : r - s;
         if (k >= GAP && d <= int'(tol)) begin
            exp_n = k + 1;
            break;
         end
      end
   endtask

   task automatic pulse_trig(input int gap);
      repeat (gap) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   // abort > 0: issue a new start after that many triggers without final checks
   task automatic run_case(input string name, input int abort, input bit probe_dec);
      int n;
      plan();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wcount = 0;
      chk(latch_clr == 1'b1, "R1 clear after start", int'(latch_clr), 1);
      chk(dac_code == 8'd255 && int'(dly_code) == DMIN, "R1 start values",
          int'(dly_code), DMIN);
      chk(count == '0 && !done, "R1 counters cleared", int'(count), 0);
      if (probe_dec) begin
         for (int i = 0; i < 3; i++) pulse_trig(2);
         @(negedge clk);
         chk(dac_code == 8'd252, "R2 one step per trigger", int'(dac_code), 252);
      end
      n = 0;
      while (!done && n < 30000) begin
         pulse_trig(2 + int'($urandom_range(0, 3)));
         n++;
         if (abort > 0 && n >= abort) return;
      end
      @(negedge clk);
      chk(done == 1'b1, {"R7 done ", name}, int'(done), 1);
      chk(int'(count) == exp_n, {"R7 sample count ", name}, int'(count), exp_n);
      chk(wcount == exp_n, {"R8 writes seen ", name}, wcount, exp_n);
      for (int i = 0; i < 4; i++) pulse_trig(2);
      chk(done && int'(count) == exp_n, "R10 done holds", int'(count), exp_n);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 32; k++) wv[k] = 255;
      exp_n = 0;
      wcount = 0;
      repeat (3) @(negedge clk);
      chk(dac_code == 8'd255, "R1 reset threshold", int'(dac_code), 255);
      chk(int'(dly_code) == DMIN, "R1 reset delay", int'(dly_code), DMIN);
      chk(!done && count == '0 && !wr_en && !latch_clr, "R1 reset flags", int'(count), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // full range, no match: ends at the last delay point (R6)
      tol = 8'd0;
      wv[0] = 255;
      for (int k = 1; k < 32; k++) wv[k] = int'($urandom_range(200, 250));
      run_case("range", 0, 1'b0);

      // periodic wave; near-reference point before the gap must not end it (R8)
      tol = 8'd2;
      wv[0] = 240;
      wv[1] = 241;
      for (int k = 2; k < 7; k++) wv[k] = int'($urandom_range(150, 230));
      for (int k = 7; k < 32; k++) wv[k] = wv[k - 7];
      run_case("period", 0, 1'b0);

      // zero-valued reference point, threshold probe (R2, R4)
      tol = 8'd1;
      wv[0] = 0;
      for (int k = 1; k < 32; k++) wv[k] = int'($urandom_range(200, 255));
      wv[4] = 2;
      run_case("zero", 0, 1'b1);

      // restart mid-capture, then random cases
      run_case("abort", 40, 1'b0);
      for (int c = 0; c < 3; c++) begin
         tol = 8'($urandom_range(0, 8));
         for (int k = 0; k < 32; k++) wv[k] = int'($urandom_range(180, 255));
         run_case("random", 0, 1'b0);
      end

      // stale latch held through clear is ignored (R9): no glitch vs glitch give same result
      glitch_en = 1'b0;
      tol = 8'd3;
      for (int k = 0; k < 32; k++) wv[k] = 230 - 4 * k;
      wv[5] = 231;
      run_case("noglitch", 0, 1'b0);
      glitch_en = 1'b1;
      run_case("glitch R9", 0, 1'b0);

      report();
   end
endmodule